// File: doc/BRIEF.md
# Keyed Configuration Port Controller

This block implements an index/data pair of byte ports on an 8-bit I/O bus. It guards a small configuration register file. After reset the port is locked. While it is locked, every byte written to the index port is fed to a key detector. The register file only becomes reachable once a fixed four-byte key has arrived in order.

Once the port is unlocked, software writes a register number to the index port. It then reads or writes that register through the data port. The file holds four things:

- a logical-device selector;
- read-only identification bytes;
- a revision nibble;
- one 16-bit base address register for each logical device.

The base address of the GPIO logical device is driven out continuously so that the GPIO block can decode its own addresses. Writing the lock value to the lock index closes the port again.

Top module: `cfg_keyport`

## Requirements
- R1: After synchronous reset the port is locked, the device selector is 0x00, the GPIO base output is 0x0A00, and read data is 0xFF.
- R2: Writing 0x87, 0x01, 0x55, 0x55 in that order to the index port (0x2E) unlocks the port on the clock edge that takes the last byte.
- R3: A key byte that does not match the expected one restarts detection. If that wrong byte is 0x87 it counts as the first key byte, so 0x87 0x87 0x01 0x55 0x55 unlocks. A partial key followed by a stray byte leaves the port locked.
- R4: While unlocked, a data-port write of 0x02 with index 0x02 selected relocks the port and clears the index. Any other value written to index 0x02 has no effect.
- R5: While unlocked, an index-port write selects the register that data-port (0x2F) accesses reach. Writes to any other bus address change nothing.
- R6: While locked, data-port reads return 0xFF and data-port writes change no register.
- R7: Index 0x07 is the 8-bit logical-device selector. It can be both read and written.
- R8: Index 0x20 reads the high byte of the chip ID and index 0x21 reads the low byte. Index 0x22 reads the revision in bits 3:0, with bits 7:4 as zero. Writes to these three indices are ignored.
- R9: An unimplemented index reads 0x00, and writes to it have no effect.
- R10: Index 0x62 (high byte) and index 0x63 (low byte) access the base register of the selected logical device. The GPIO base output always shows device 7's register. Device 7 resets to 0x0A00 and the other devices reset to 0x0000. A selector at or above the device count reads 0x00 and ignores writes.
- R11: Read data is combinational from the current address and state. Any address other than the data port of an unlocked port reads 0xFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | 16 | I/O bus address |
| io_wr | input | 1 | Write strobe, one byte per cycle |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data for the addressed port |
| cfg_unlocked | output | 1 | High while the register file is open |
| cfg_ldn | output | 8 | Current logical-device selector |
| gpio_base | output | 16 | Base address of the GPIO logical device |

## Verification
The assertions assume that a write strobe lasts exactly one cycle per byte. They also assume that the address and data are stable across the sampling edge, with no reads that have side effects. The stimulus drives every bus change on the falling edge and holds it for a full cycle, with single-cycle strobes separated by idle or read cycles. The stimulus covers partial keys, stray bytes and repeated 0x87 restarts. It also issues writes to read-only, unimplemented and out-of-range targets. A behavioural model tracks key progress and register contents with plain integers and is compared with every output each cycle.

// File: rtl/cfg_keyport_pkg.sv
package cfg_keyport_pkg;

    localparam logic [7:0] IDX_LOCK    = 8'h02;
    localparam logic [7:0] IDX_LDN     = 8'h07;
    localparam logic [7:0] IDX_ID_HI   = 8'h20;
    localparam logic [7:0] IDX_ID_LO   = 8'h21;
    localparam logic [7:0] IDX_REV     = 8'h22;
    localparam logic [7:0] IDX_BASE_HI = 8'h62;
    localparam logic [7:0] IDX_BASE_LO = 8'h63;
    localparam logic [7:0] LOCK_VAL    = 8'h02;
    localparam logic [7:0] OPEN_BUS    = 8'hFF;

    typedef enum logic [2:0] {
        KS_S0   = 3'd0,
        KS_S1   = 3'd1,
        KS_S2   = 3'd2,
        KS_S3   = 3'd3,
        KS_OPEN = 3'd4
    } key_state_t;

    typedef struct packed {
        logic       idx_wr;
        logic       dat_wr;
        logic       dat_sel;
        logic [7:0] wdata;
    } cfg_bus_t;

    function automatic logic [7:0] key_at(input logic [1:0] step);
        case (step)
            2'd0:    return 8'h87;
            2'd1:    return 8'h01;
            default: return 8'h55;
        endcase
    endfunction

    function automatic key_state_t key_next(input key_state_t s);
        case (s)
            KS_S0:   return KS_S1;
            KS_S1:   return KS_S2;
            KS_S2:   return KS_S3;
            default: return KS_OPEN;
        endcase
    endfunction

endpackage

// File: rtl/cfg_key_seq.sv
module cfg_key_seq
    import cfg_keyport_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       key_wr,
    input  logic [7:0] key_byte,
    input  logic       relock,
    output logic       unlocked
);
    key_state_t st;
    logic [1:0] step;

    assign step     = st[1:0];
    assign unlocked = (st == KS_OPEN);

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= KS_S0;
        end else if (st == KS_OPEN) begin
            if (relock) st <= KS_S0;
        end else if (key_wr) begin
            if (key_byte == key_at(step))
                st <= key_next(st);
            else if (key_byte == key_at(2'd0))
                st <= KS_S1;
            else
                st <= KS_S0;
        end
    end
endmodule

// File: rtl/cfg_regs.sv
module cfg_regs
    import cfg_keyport_pkg::*;
#(
    parameter int          NUM_LDN       = 8,
    parameter int          GPIO_LDN      = 7,
    parameter logic [15:0] GPIO_BASE_RST = 16'h0A00
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        unlocked,
    input  logic        idx_wr,
    input  logic        dat_wr,
    input  logic [7:0]  wdata,
    output logic [7:0]  cur_index,
    output logic [7:0]  cur_ldn,
    output logic [15:0] sel_base,
    output logic [15:0] gpio_base,
    output logic        relock
);
    localparam int         LDN_W     = (NUM_LDN > 1) ? $clog2(NUM_LDN) : 1;
    localparam logic [7:0] LDN_LIMIT = 8'(NUM_LDN);

    logic [15:0]      base_q [NUM_LDN];
    logic             ldn_ok;
    logic [LDN_W-1:0] ldn_slot;
    logic             open_wr;
    logic             wr_hi;
    logic             wr_lo;

    assign open_wr  = unlocked & dat_wr;
    assign ldn_ok   = (cur_ldn < LDN_LIMIT);
    assign ldn_slot = cur_ldn[LDN_W-1:0];
    assign wr_hi    = open_wr & ldn_ok & (cur_index == IDX_BASE_HI);
    assign wr_lo    = open_wr & ldn_ok & (cur_index == IDX_BASE_LO);
    assign relock   = open_wr & (cur_index == IDX_LOCK) & (wdata == LOCK_VAL);

    always_ff @(posedge clk) begin
        if (rst)
            cur_index <= 8'h00;
        else if (relock)
            cur_index <= 8'h00;
        else if (unlocked & idx_wr)
            cur_index <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst)
            cur_ldn <= 8'h00;
        else if (open_wr & (cur_index == IDX_LDN))
            cur_ldn <= wdata;
    end

    for (genvar g = 0; g < NUM_LDN; g++) begin : g_base
        localparam logic [15:0] RST_VAL = (g == GPIO_LDN) ? GPIO_BASE_RST : 16'h0000;
        logic hit;
        assign hit = (ldn_slot == LDN_W'(g));
        always_ff @(posedge clk) begin
            if (rst)
                base_q[g] <= RST_VAL;
            else if (wr_hi & hit)
                base_q[g][15:8] <= wdata;
            else if (wr_lo & hit)
                base_q[g][7:0] <= wdata;
        end
    end

    assign sel_base  = ldn_ok ? base_q[ldn_slot] : 16'h0000;
    assign gpio_base = base_q[GPIO_LDN];
endmodule

// File: rtl/cfg_rdmux.sv
module cfg_rdmux
    import cfg_keyport_pkg::*;
#(
    parameter logic [15:0] CHIP_ID  = 16'hC5A3,
    parameter logic [3:0]  CHIP_REV = 4'h2
) (
    input  logic        unlocked,
    input  logic        dat_sel,
    input  logic [7:0]  cur_index,
    input  logic [7:0]  cur_ldn,
    input  logic [15:0] sel_base,
    output logic [7:0]  rdata
);
    always_comb begin
        if (!(unlocked & dat_sel)) begin
            rdata = OPEN_BUS;
        end else begin
            case (cur_index)
                IDX_LDN:     rdata = cur_ldn;
                IDX_ID_HI:   rdata = CHIP_ID[15:8];
                IDX_ID_LO:   rdata = CHIP_ID[7:0];
                IDX_REV:     rdata = {4'h0, CHIP_REV};
                IDX_BASE_HI: rdata = sel_base[15:8];
                IDX_BASE_LO: rdata = sel_base[7:0];
                default:     rdata = 8'h00;
            endcase
        end
    end
endmodule

// File: rtl/cfg_keyport.sv
module cfg_keyport
    import cfg_keyport_pkg::*;
#(
    parameter int          ADDR_W        = 16,
    parameter logic [15:0] INDEX_PORT    = 16'h002E,
    parameter logic [15:0] DATA_PORT     = 16'h002F,
    parameter logic [15:0] CHIP_ID       = 16'hC5A3,
    parameter logic [3:0]  CHIP_REV      = 4'h2,
    parameter int          NUM_LDN       = 8,
    parameter int          GPIO_LDN      = 7,
    parameter logic [15:0] GPIO_BASE_RST = 16'h0A00
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_wr,
    input  logic [7:0]        io_wdata,
    output logic [7:0]        io_rdata,
    output logic              cfg_unlocked,
    output logic [7:0]        cfg_ldn,
    output logic [15:0]       gpio_base
);
    cfg_bus_t    bus;
    logic        relock;
    logic [7:0]  cur_index;
    logic [15:0] sel_base;

    always_comb begin
        bus.dat_sel = (io_addr == ADDR_W'(DATA_PORT));
        bus.idx_wr  = io_wr & (io_addr == ADDR_W'(INDEX_PORT));
        bus.dat_wr  = io_wr & bus.dat_sel;
        bus.wdata   = io_wdata;
    end

    cfg_key_seq u_key (
        .clk      (clk),
        .rst      (rst),
        .key_wr   (bus.idx_wr),
        .key_byte (bus.wdata),
        .relock   (relock),
        .unlocked (cfg_unlocked)
    );

    cfg_regs #(
        .NUM_LDN       (NUM_LDN),
        .GPIO_LDN      (GPIO_LDN),
        .GPIO_BASE_RST (GPIO_BASE_RST)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .unlocked  (cfg_unlocked),
        .idx_wr    (bus.idx_wr),
        .dat_wr    (bus.dat_wr),
        .wdata     (bus.wdata),
        .cur_index (cur_index),
        .cur_ldn   (cfg_ldn),
        .sel_base  (sel_base),
        .gpio_base (gpio_base),
        .relock    (relock)
    );

    cfg_rdmux #(
        .CHIP_ID  (CHIP_ID),
        .CHIP_REV (CHIP_REV)
    ) u_rd (
        .unlocked  (cfg_unlocked),
        .dat_sel   (bus.dat_sel),
        .cur_index (cur_index),
        .cur_ldn   (cfg_ldn),
        .sel_base  (sel_base),
        .rdata     (io_rdata)
    );
endmodule

// File: rtl/cfg_keyport_chk.sv
module cfg_keyport_chk #(
    parameter int          ADDR_W     = 16,
    parameter logic [15:0] INDEX_PORT = 16'h002E,
    parameter logic [15:0] DATA_PORT  = 16'h002F,
    parameter logic [15:0] CHIP_ID    = 16'hC5A3
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] io_addr,
    input logic              io_wr,
    input logic [7:0]        io_wdata,
    input logic [7:0]        io_rdata,
    input logic              cfg_unlocked,
    input logic [7:0]        cfg_ldn,
    input logic [15:0]       gpio_base,
    input logic [7:0]        cur_index
);
    logic at_data, at_index;
    assign at_data  = (io_addr == ADDR_W'(DATA_PORT));
    assign at_index = (io_addr == ADDR_W'(INDEX_PORT));

    p_locked_reads_ff_r6: assert property (@(posedge clk) disable iff (rst)
        !cfg_unlocked |-> io_rdata == 8'hFF);

    p_locked_writes_dropped_r6: assert property (@(posedge clk) disable iff (rst)
        (!cfg_unlocked && io_wr && at_data) |=> ($stable(cfg_ldn) && $stable(gpio_base)));

    p_open_needs_key_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(cfg_unlocked) |-> $past(io_wr && at_index && io_wdata == 8'h55));

    p_relock_r4: assert property (@(posedge clk) disable iff (rst)
        (cfg_unlocked && io_wr && at_data && cur_index == 8'h02 && io_wdata == 8'h02)
        |=> !cfg_unlocked);

    p_ldn_write_r7: assert property (@(posedge clk) disable iff (rst)
        (cfg_unlocked && io_wr && at_data && cur_index == 8'h07)
        |=> cfg_ldn == $past(io_wdata));

    p_id_high_r8: assert property (@(posedge clk) disable iff (rst)
        (cfg_unlocked && at_data && cur_index == 8'h20) |-> io_rdata == CHIP_ID[15:8]);

    p_other_addr_ff_r11: assert property (@(posedge clk) disable iff (rst)
        !at_data |-> io_rdata == 8'hFF);
endmodule

bind cfg_keyport cfg_keyport_chk #(
    .ADDR_W     (ADDR_W),
    .INDEX_PORT (INDEX_PORT),
    .DATA_PORT  (DATA_PORT),
    .CHIP_ID    (CHIP_ID)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .io_addr      (io_addr),
    .io_wr        (io_wr),
    .io_wdata     (io_wdata),
    .io_rdata     (io_rdata),
    .cfg_unlocked (cfg_unlocked),
    .cfg_ldn      (cfg_ldn),
    .gpio_base    (gpio_base),
    .cur_index    (cur_index)
);

// File: tb/sim_cfg_keyport.sv
`timescale 1ns/1ps
module sim_cfg_keyport;
    localparam int IDXP = 16'h002E;
    localparam int DATP = 16'h002F;
    localparam int ID   = 16'hC5A3;
    localparam int REV  = 4'h2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] io_addr = 16'h0000;
    logic        io_wr = 1'b0;
    logic [7:0]  io_wdata = 8'h00;
    logic [7:0]  io_rdata;
    logic        cfg_unlocked;
    logic [7:0]  cfg_ldn;
    logic [15:0] gpio_base;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    cfg_keyport u0 (
        .clk(clk), .rst(rst), .io_addr(io_addr), .io_wr(io_wr),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .cfg_unlocked(cfg_unlocked),
        .cfg_ldn(cfg_ldn), .gpio_base(gpio_base)
    );

    // behavioural reference
    int m_step, m_open, m_idx, m_ldn;
    int m_base [8];
    int key_seq [4] = '{8'h87, 8'h01, 8'h55, 8'h55};

    task automatic model_reset();
        m_step = 0; m_open = 0; m_idx = 0; m_ldn = 0;
        for (int i = 0; i < 8; i++) m_base[i] = (i == 7) ? 16'h0A00 : 0;
    endtask

    initial model_reset();

    always @(posedge clk) begin
        if (rst) begin
            model_reset();
        end else if (io_wr) begin
            if (int'(io_addr) == IDXP) begin
                if (m_open == 0) begin
                    if (int'(io_wdata) == key_seq[m_step]) begin
                        if (m_step == 3) begin m_open = 1; m_step = 0; end
                        else m_step++;
                    end else if (io_wdata == 8'h87) m_step = 1;
                    else m_step = 0;
                end else m_idx = int'(io_wdata);
            end else if (int'(io_addr) == DATP && m_open == 1) begin
                if (m_idx == 2) begin
                    if (io_wdata == 8'h02) begin m_open = 0; m_idx = 0; end
                end else if (m_idx == 7) m_ldn = int'(io_wdata);
                else if (m_idx == 8'h62 && m_ldn < 8)
                    m_base[m_ldn] = (int'(io_wdata) << 8) | (m_base[m_ldn] & 8'hFF);
                else if (m_idx == 8'h63 && m_ldn < 8)
                    m_base[m_ldn] = (m_base[m_ldn] & 16'hFF00) | int'(io_wdata);
            end
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        #3;
        if (!rst) begin
            int er;
            string tg;
            if (!(m_open == 1 && int'(io_addr) == DATP)) begin
                er = 8'hFF; tg = (m_open == 1) ? "R11" : "R6";
            end else begin
                case (m_idx)
                    7:       begin er = m_ldn; tg = "R7"; end
                    8'h20:   begin er = ID >> 8; tg = "R8"; end
                    8'h21:   begin er = ID & 8'hFF; tg = "R8"; end
                    8'h22:   begin er = REV; tg = "R8"; end
                    8'h62:   begin er = (m_ldn < 8) ? (m_base[m_ldn] >> 8) : 0; tg = "R10"; end
                    8'h63:   begin er = (m_ldn < 8) ? (m_base[m_ldn] & 8'hFF) : 0; tg = "R10"; end
                    default: begin er = 0; tg = "R9"; end
                endcase
            end
            check(int'(io_rdata) == er, tg, int'(io_rdata), er);
            check(int'(cfg_unlocked) == m_open, "R2 unlock state", int'(cfg_unlocked), m_open);
            check(int'(cfg_ldn) == m_ldn, "R7 selector", int'(cfg_ldn), m_ldn);
            check(int'(gpio_base) == m_base[7], "R10 gpio base", int'(gpio_base), m_base[7]);
        end
    end

    task automatic wr(input int a, input int d);
        @(negedge clk);
        io_addr = 16'(a); io_wdata = 8'(d); io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic look(input int a);
        @(negedge clk);
        io_addr = 16'(a); io_wr = 1'b0;
    endtask

    task automatic key();
        wr(IDXP, 8'h87); wr(IDXP, 8'h01); wr(IDXP, 8'h55); wr(IDXP, 8'h55);
    endtask

    task automatic rd_expect(input int idx, input int exp, input string tag);
        wr(IDXP, idx);
        look(DATP);
        #2 check(int'(io_rdata) == exp, tag, int'(io_rdata), exp);
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                rst = 1'b0;
                #1;
                check(cfg_unlocked == 1'b0, "R1 locked", int'(cfg_unlocked), 0);
                check(gpio_base == 16'h0A00, "R1 base", int'(gpio_base), 16'h0A00);
                check(cfg_ldn == 8'h00, "R1 ldn", int'(cfg_ldn), 0);
                check(io_rdata == 8'hFF, "R1 rdata", int'(io_rdata), 8'hFF);
                // R6: locked data access
                wr(DATP, 8'h03);
                look(DATP);
                #2 check(io_rdata == 8'hFF, "R6 locked read", int'(io_rdata), 8'hFF);
                check(cfg_ldn == 8'h00, "R6 write dropped", int'(cfg_ldn), 0);
                // R3: broken key stays locked
                wr(IDXP, 8'h87); wr(IDXP, 8'h01); wr(IDXP, 8'h55); wr(IDXP, 8'h12);
                wr(IDXP, 8'h55);
                #2 check(cfg_unlocked == 1'b0, "R3 broken key", int'(cfg_unlocked), 0);
                // R3: repeated 0x87 restarts
                wr(IDXP, 8'h87); wr(IDXP, 8'h01); wr(IDXP, 8'h87);
                key();
                #2 check(cfg_unlocked == 1'b1, "R3 restart unlock", int'(cfg_unlocked), 1);
                // R8
                rd_expect(8'h20, ID >> 8, "R8 id hi");
                rd_expect(8'h21, ID & 8'hFF, "R8 id lo");
                rd_expect(8'h22, REV, "R8 rev");
                wr(DATP, 8'hEE);
                rd_expect(8'h22, REV, "R8 rev write ignored");
                // R9
                wr(IDXP, 8'h30); wr(DATP, 8'h5A);
                rd_expect(8'h30, 0, "R9 unimplemented");
                // R7 / R10
                wr(IDXP, 8'h07); wr(DATP, 8'h07);
                rd_expect(8'h07, 7, "R7 ldn readback");
                wr(IDXP, 8'h62); wr(DATP, 8'h12);
                wr(IDXP, 8'h63); wr(DATP, 8'h34);
                #2 check(gpio_base == 16'h1234, "R10 gpio base", int'(gpio_base), 16'h1234);
                wr(IDXP, 8'h07); wr(DATP, 8'h03);
                wr(IDXP, 8'h62); wr(DATP, 8'hAB);
                #2 check(gpio_base == 16'h1234, "R10 other ldn", int'(gpio_base), 16'h1234);
                rd_expect(8'h62, 8'hAB, "R10 ldn3 hi");
                wr(IDXP, 8'h07); wr(DATP, 8'h20);
                wr(IDXP, 8'h63); wr(DATP, 8'h77);
                rd_expect(8'h63, 0, "R10 out of range");
                // R5: foreign address ignored
                wr(IDXP, 8'h07); wr(16'h0080, 8'h05);
                #2 check(cfg_ldn == 8'h20, "R5 foreign addr", int'(cfg_ldn), 8'h20);
                look(IDXP);
                #2 check(io_rdata == 8'hFF, "R11 index port read", int'(io_rdata), 8'hFF);
                // R4
                wr(IDXP, 8'h02); wr(DATP, 8'h01);
                #2 check(cfg_unlocked == 1'b1, "R4 wrong lock value", int'(cfg_unlocked), 1);
                wr(DATP, 8'h02);
                #2 check(cfg_unlocked == 1'b0, "R4 relocked", int'(cfg_unlocked), 0);
                wr(DATP, 8'h07);
                look(DATP);
                #2 check(io_rdata == 8'hFF, "R6 after relock", int'(io_rdata), 8'hFF);
                key();
                #2 check(cfg_unlocked == 1'b1, "R2 reopen", int'(cfg_unlocked), 1);
                look(DATP);
                #2 check(io_rdata == 8'h00, "R4 index cleared", int'(io_rdata), 0);
                repeat (3) @(negedge clk);
                done = 1;
            end
            begin
                repeat (20000) @(posedge clk);
                if (!done) begin
                    checks++; errors++;
                    $display("FAIL watchdog: actual hung expected done");
                end
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule